// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit

This block keeps the pending-interrupt flags and the interrupt enables of a small 8-bit peripheral and drives one level-sensitive interrupt line toward the processor. Sources inside the peripheral (a shift-register engine and two timers) raise flags with one-cycle set pulses. Other register reads elsewhere in the peripheral have side effects, and these arrive as one-cycle clear pulses. Software sees the unit at two register indices of the peripheral's register file: the flag register (index 13) and the enable register (index 14).

Each cycle the top decodes the register access into an access kind of type `ifu_access_t`. There are three values. `ACC_NONE` means no write, or a write to any other index. `ACC_FLAG_WR` is a write to index 13 and clears flags. `ACC_ENABLE_WR` is a write to index 14; bit 7 of the written byte chooses whether the enables are set or cleared. The access kind depends on the inputs of the current cycle only, so the choice moves from one value to another without any stored state. The flag bank and the enable bank are registered. The read data and the interrupt line are combinational from those registers.

The flag bits in use sit at fixed positions: shift register at bit 2, timer 2 at bit 5 and timer 1 at bit 6. Only the shift-register and timer-1 sources can drive the interrupt line. A pending and enabled timer-2 flag is visible in the summary bit of a flag read, but it never raises the line.

Top module: `ifu_top`

## Requirements
- R1: A write to index 14 with bit 7 = 1 sets every enable bit i (0..6) for which bit i of the written byte is 1 and leaves the other enables unchanged.
- R2: A write to index 14 with bit 7 = 0 clears every enable bit i for which bit i of the written byte is 1 and leaves the other enables unchanged.
- R3: While index 14 is selected, rd_data is {1'b1, enables[6:0]}.
- R4: A write to index 13 clears every flag bit i for which bit i of the written byte is 1; bit 7 of the written byte has no effect.
- R5: While index 13 is selected, rd_data is {s, flags[6:0]}, where s = 1 exactly when (flags & enables) is nonzero.
- R6: A 1 on set_pulse[i] sets flag i at the next clock edge. The shift-register source drives bit 2, timer 2 drives bit 5 and timer 1 drives bit 6.
- R7: irq is 1 exactly while (flags & enables & 7'h44) is nonzero. This means only bit 2 (shift register) and bit 6 (timer 1) can raise it.
- R8: After reset, the flags and the enables are zero: reading index 13 gives 8'h00, reading index 14 gives 8'h80, and irq is 0.
- R9: If set_pulse[i] is 1 in the same cycle as a clear of flag i (from clr_pulse or from a flag-register write), the flag ends up set.
- R10: A 1 on clr_pulse[i] clears flag i at the next clock edge, unless R9 applies.
- R11: A write to any index other than 13 or 14 changes neither flags nor enables. Reading any other index returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 4 | Register index of the current access |
| wr_en | input | 1 | Write strobe for the selected index |
| wr_data | input | 8 | Write data |
| set_pulse | input | 7 | One-cycle flag set requests, one bit per flag |
| clr_pulse | input | 7 | One-cycle flag clear requests from side-effect reads |
| rd_data | output | 8 | Read data of the selected index |
| irq | output | 1 | Level interrupt request |

## Verification
The clocked properties assume that set and clear requests are not driven while reset is held. They also assume that wr_en, reg_sel and wr_data are stable across each rising edge. The stimulus changes these inputs only just after an edge and keeps every pulse low during reset. The sweep applies every enable pattern against every flag pattern and compares the result with arithmetic on the two 7-bit values. Simultaneous set and clear requests are driven as a full sweep over the set pattern, with every clear source active.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
    localparam int FLAG_W     = 7;
    localparam int DATA_W     = FLAG_W + 1;
    localparam int IDX_W      = 4;
    localparam int FLAG_IDX   = 13;
    localparam int ENABLE_IDX = 14;
    localparam int BIT_SR     = 2;
    localparam int BIT_T2     = 5;
    localparam int BIT_T1     = 6;
    localparam logic [FLAG_W-1:0] IRQ_MASK =
        (FLAG_W'(1) << BIT_SR) | (FLAG_W'(1) << BIT_T1);

    typedef enum logic [1:0] {
        ACC_NONE      = 2'd0,
        ACC_FLAG_WR   = 2'd1,
        ACC_ENABLE_WR = 2'd2
    } ifu_access_t;
endpackage

// File: rtl/ifu_flag_bank.sv
module ifu_flag_bank #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_pulse,
    input  logic [W-1:0] clr_pulse,
    input  logic         wr_clr_en,
    input  logic [W-1:0] wr_clr_mask,
    output logic [W-1:0] flags
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (set_pulse[i])
                flags[i] <= 1'b1;
            else if (clr_pulse[i] || (wr_clr_en && wr_clr_mask[i]))
                flags[i] <= 1'b0;
        end
    end

    // R6 / R9: a set request always lands, whatever clears arrive with it
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_pulse) |=> ((flags & $past(set_pulse)) == $past(set_pulse)));

    // R4: register-write clear removes the addressed flags
    assert_write_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr_en |=> ((flags & $past(wr_clr_mask) & ~$past(set_pulse)) == '0));

    // R10: side-effect clear removes the addressed flags
    assert_pulse_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_pulse) |=> ((flags & $past(clr_pulse) & ~$past(set_pulse)) == '0));

    // R11: with no request at all the flags hold
    assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_clr_en && set_pulse == '0 && clr_pulse == '0) |=> $stable(flags));
endmodule

// File: rtl/ifu_enable_bank.sv
module ifu_enable_bank #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_set,
    input  logic [W-1:0] wr_mask,
    output logic [W-1:0] enables
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                enables[i] <= 1'b0;
            else if (wr_en && wr_mask[i])
                enables[i] <= wr_set;
        end
    end

    assert_enable_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_set) |=> ((enables & $past(wr_mask)) == $past(wr_mask)));

    assert_enable_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_set) |=> ((enables & $past(wr_mask)) == '0));

    assert_enable_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((enables & ~$past(wr_mask)) == ($past(enables) & ~$past(wr_mask))));
endmodule

// File: rtl/ifu_irq_gen.sv
module ifu_irq_gen #(
    parameter int           W    = 7,
    parameter logic [W-1:0] MASK = 7'h44
) (
    input  logic [W-1:0] flags,
    input  logic [W-1:0] enables,
    output logic         pending_any,
    output logic         irq
);
    logic [W-1:0] active;

    always_comb begin
        active      = flags & enables;
        pending_any = |active;
        irq         = |(active & MASK);
    end

    // R7: the line is a subset of the summary
    always_comb begin
        assert_irq_implies_summary_R7: assert (!irq || pending_any);
    end
endmodule

// File: rtl/ifu_top.sv
module ifu_top
    import ifu_pkg::*;
#(
    parameter int FW       = FLAG_W,
    parameter int IW       = IDX_W,
    parameter int F_IDX    = FLAG_IDX,
    parameter int E_IDX    = ENABLE_IDX
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] reg_sel,
    input  logic          wr_en,
    input  logic [FW:0]   wr_data,
    input  logic [FW-1:0] set_pulse,
    input  logic [FW-1:0] clr_pulse,
    output logic [FW:0]   rd_data,
    output logic          irq
);
    localparam logic [IW-1:0] SEL_FLAG   = IW'(F_IDX);
    localparam logic [IW-1:0] SEL_ENABLE = IW'(E_IDX);
    localparam logic [FW-1:0] LINE_MASK  = FW'(IRQ_MASK);

    ifu_access_t   acc;
    logic          flag_wr;
    logic          en_wr;
    logic [FW-1:0] flags;
    logic [FW-1:0] enables;
    logic          pending_any;

    always_comb begin
        acc = ACC_NONE;
        if (wr_en && reg_sel == SEL_FLAG)
            acc = ACC_FLAG_WR;
        else if (wr_en && reg_sel == SEL_ENABLE)
            acc = ACC_ENABLE_WR;
    end

    always_comb begin
        flag_wr = 1'b0;
        en_wr   = 1'b0;
        unique case (acc)
            ACC_FLAG_WR:   flag_wr = 1'b1;
            ACC_ENABLE_WR: en_wr   = 1'b1;
            default:       ;
        endcase
    end

    ifu_flag_bank #(.W(FW)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_pulse   (set_pulse),
        .clr_pulse   (clr_pulse),
        .wr_clr_en   (flag_wr),
        .wr_clr_mask (wr_data[FW-1:0]),
        .flags       (flags)
    );

    ifu_enable_bank #(.W(FW)) u_enables (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (en_wr),
        .wr_set  (wr_data[FW]),
        .wr_mask (wr_data[FW-1:0]),
        .enables (enables)
    );

    ifu_irq_gen #(.W(FW), .MASK(LINE_MASK)) u_irq (
        .flags       (flags),
        .enables     (enables),
        .pending_any (pending_any),
        .irq         (irq)
    );

    always_comb begin
        if (reg_sel == SEL_FLAG)
            rd_data = {pending_any, flags};
        else if (reg_sel == SEL_ENABLE)
            rd_data = {1'b1, enables};
        else
            rd_data = '0;
    end

    // R3: enable read always reports bit 7 high
    always_comb begin
        assert_enable_read_top_R3: assert (reg_sel != SEL_ENABLE || rd_data[FW]);
    end

    // R7: a raised line is always visible in a flag read summary
    assert_irq_summary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && reg_sel == SEL_FLAG) |-> rd_data[FW]);
endmodule

// File: tb/tb_ifu_top.sv
module tb_ifu_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_sel = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [6:0] set_pulse = '0;
    logic [6:0] clr_pulse = '0;
    logic [7:0] rd_data;
    logic       irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ifu_top dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .wr_data(wr_data), .set_pulse(set_pulse), .clr_pulse(clr_pulse),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] idx, input logic [7:0] d);
        reg_sel = idx; wr_data = d; wr_en = 1'b1;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(input logic [6:0] s, input logic [6:0] c);
        set_pulse = s; clr_pulse = c;
        step();
        set_pulse = '0; clr_pulse = '0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [7:0] v);
        reg_sel = idx;
        #1;
        v = rd_data;
    endtask

    function automatic logic [7:0] flag_word(logic [6:0] f, logic [6:0] e);
        return {(f & e) != 7'd0, f};
    endfunction

    function automatic logic [7:0] line(logic [6:0] f, logic [6:0] e);
        return {7'd0, (f & e & 7'h44) != 7'd0};
    endfunction

    initial begin
        logic [7:0] v;
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R8 reset state
        rd(4'd13, v); check("R8 flags after reset", v, 8'h00);
        rd(4'd14, v); check("R8/R3 enables after reset", v, 8'h80);
        check("R8 irq after reset", {7'd0, irq}, 8'h00);

        // R1 R3 R5 R6 R7 sweep: every enable pattern against every flag pattern
        for (int e = 0; e < 128; e++) begin
            wr(4'd14, 8'h7F);
            wr(4'd14, 8'h80 | 8'(e));
            for (int f = 0; f < 128; f++) begin
                wr(4'd13, 8'h7F);
                pulse(7'(f), 7'd0);
                rd(4'd13, v); check("R5/R6 flag read", v, flag_word(7'(f), 7'(e)));
                rd(4'd14, v); check("R1/R3 enable read", v, {1'b1, 7'(e)});
                check("R7 irq level", {7'd0, irq}, line(7'(f), 7'(e)));
            end
        end

        // R2 partial enable clear
        wr(4'd14, 8'hFF);
        wr(4'd14, 8'h05);
        rd(4'd14, v); check("R2 partial enable clear", v, 8'hFA);
        wr(4'd14, 8'h80 | 8'h10);
        rd(4'd14, v); check("R1 set keeps others", v, 8'hFA);

        // R4 flag write clear, bit 7 ignored
        pulse(7'h7F, 7'd0);
        wr(4'd13, 8'hA1);
        rd(4'd13, v); check("R4 flag write clear", v, 8'hDE);

        // R10 pulse clear
        pulse(7'd0, 7'h44);
        rd(4'd13, v); check("R10 clear pulse", v, 8'h9A);

        // R7 timer 2 alone never drives the line
        wr(4'd13, 8'h7F);
        wr(4'd14, 8'hFF);
        pulse(7'h20, 7'd0);
        check("R7 timer2 no line", {7'd0, irq}, 8'h00);
        rd(4'd13, v); check("R5 timer2 summary", v, 8'hA0);

        // R9 set beats every clear in the same cycle
        for (int s = 0; s < 128; s++) begin
            wr(4'd13, 8'h7F);
            reg_sel = 4'd13; wr_data = 8'h7F; wr_en = 1'b1;
            pulse(7'(s), 7'h7F);
            wr_en = 1'b0; wr_data = '0;
            rd(4'd13, v); check("R9 set priority", v, flag_word(7'(s), 7'h7F));
        end

        // R11 other indices ignored, read zero
        wr(4'd13, 8'h7F);
        wr(4'd14, 8'h7F);
        wr(4'd14, 8'h80 | 8'h44);
        pulse(7'h15, 7'd0);
        for (int k = 0; k < 16; k++) begin
            if (k == 13 || k == 14) continue;
            wr(4'(k), 8'hFF);
            rd(4'(k), v); check("R11 other index reads zero", v, 8'h00);
            rd(4'd13, v); check("R11 flags untouched", v, 8'h95);
            rd(4'd14, v); check("R11 enables untouched", v, 8'hC4);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule